// File: doc/BRIEF.md
# Sample-to-Memory Write Master

This block moves 32-bit samples from a slow converter into a buffer in system memory. The converter runs in its own clock domain and raises a ready strobe for each new word. The block brings that strobe into the system clock domain through a two-flop synchronizer. It detects the rising edge and captures the data word. It then issues one single-word write on a memory-mapped master port that honours waitrequest.

Writes start at a base address that software-side logic loads once. The address moves forward by one 32-bit word after every completed write. The block raises the write strobe whenever it has a sample and keeps it raised until the slave drops waitrequest. There is no separate wait for the bus to become free.

The controller has three named states:
- `ST_IDLE`: waiting for a sample.
- `ST_PEND`: a write is on the bus.
- `ST_ADV`: the word counter steps forward.

The transitions are:
- `ST_IDLE` to `ST_PEND` on a synchronized strobe edge.
- `ST_PEND` to `ST_ADV` on the first edge where waitrequest is low.
- `ST_ADV` to `ST_IDLE` unconditionally.

A strobe edge that arrives outside `ST_IDLE` drops its sample and sets a sticky overflow flag.

Top module: `smpl_wr_master`

## Requirements
- R1: While `rst_n` is low, and after its release, `bus_write` and `overflow` are 0 and `bus_addr` is 0.
- R2: Each rising edge of `smp_valid` that the block sees in `ST_IDLE` produces exactly one write, however long the strobe stays high.
- R3: `bus_wdata` of that write equals the `smp_data` value present when the synchronized strobe edge is taken.
- R4: While `bus_write` is 1 and `bus_wait` is 1 at a rising clock edge, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged into the next cycle.
- R5: A write completes on the first rising edge with `bus_write` 1 and `bus_wait` 0. `bus_write` is 0 in the cycle after that edge.
- R6: `bus_addr[1:0]` is always 0. Writes after a load go to the loaded word address, and each completed write advances the next address by 4.
- R7: A pulse on `base_load` in `ST_IDLE` sets the word address to `base_addr[31:2]`. A pulse while a write is pending or the address is advancing is ignored.
- R8: A strobe edge seen while not in `ST_IDLE` produces no write and sets `overflow`. `overflow` then stays 1 until reset, and the pending write keeps its data and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample-ready strobe from the converter domain |
| smp_data | input | 32 | Sample word, stable around the strobe |
| base_load | input | 1 | Load the buffer start address |
| base_addr | input | 32 | Buffer start byte address |
| bus_wait | input | 1 | Slave waitrequest |
| bus_write | output | 1 | Write strobe, registered |
| bus_addr | output | 32 | Word-aligned byte address, registered |
| bus_wdata | output | 32 | Write data, registered |
| overflow | output | 1 | Sticky flag for a dropped sample |

## Verification
The assertions assume the slave may hold `bus_wait` high for any number of cycles but changes it only between clock edges. They also assume `smp_data` is steady for several system cycles around each strobe edge. The stimulus drives `bus_wait` just after each rising edge from a repeating stall pattern, with at most three stalled cycles in a row, plus a forced stall for the overflow and load-ignore cases. Each strobe is held for many cycles, with the data set before the strobe rises and kept until the next sample, which matches a converter far slower than the system clock.

// File: rtl/smw_pkg.sv
package smw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ADV  = 2'd2
    } smw_state_e;

endpackage

// File: rtl/smw_sync.sv
// Synchronizer chain for an asynchronous strobe, followed by rising-edge detection.
module smw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    assign rise = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/smw_word_ctr.sv
// Word address counter; the byte address has its two low bits tied to zero.
module smw_word_ctr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (load)    word_q <= load_addr[ADDR_W-1:2];
        else if (advance) word_q <= word_q + WORD_W'(1);
    end

    assign addr = {word_q, 2'b00};
endmodule

// File: rtl/smw_fsm.sv
// Write sequencer: idle, pending write, address advance.
module smw_fsm
    import smw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic [DATA_W-1:0] din,
    input  logic              bus_wait,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              overflow,
    output logic              load_ok,
    output logic              advance
);
    smw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rise)      state_d = ST_PEND;
            ST_PEND: if (!bus_wait) state_d = ST_ADV;
            ST_ADV:                 state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_write <= 1'b0;
            bus_wdata <= '0;
            overflow  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rise) begin
                        bus_write <= 1'b1;
                        bus_wdata <= din;
                    end
                end
                ST_PEND: begin
                    if (rise)      overflow  <= 1'b1;
                    if (!bus_wait) bus_write <= 1'b0;
                end
                ST_ADV: begin
                    if (rise) overflow <= 1'b1;
                end
                default: bus_write <= 1'b0;
            endcase
        end
    end

    assign load_ok = (state_q == ST_IDLE);
    assign advance = (state_q == ST_ADV);
endmodule

// File: rtl/smpl_wr_master.sv
module smpl_wr_master #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              bus_wait,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              overflow
);
    logic smp_rise;
    logic load_ok;
    logic advance;

    smw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (smp_valid),
        .rise     (smp_rise)
    );

    smw_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (smp_rise),
        .din       (smp_data),
        .bus_wait  (bus_wait),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .overflow  (overflow),
        .load_ok   (load_ok),
        .advance   (advance)
    );

    smw_word_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (base_load & load_ok),
        .load_addr (base_addr),
        .advance   (advance),
        .addr      (bus_addr)
    );
endmodule

// File: rtl/smpl_wr_master_chk.sv
module smpl_wr_master_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_write,
    input logic              bus_wait,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              overflow,
    input logic              base_load
);
    AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write && bus_wait |=> bus_write && $stable(bus_addr) && $stable(bus_wdata)); // R4

    AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write && !bus_wait |=> !bus_write); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_write) |=> bus_addr == $past(bus_addr) + ADDR_W'(4)); // R6

    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write && base_load |=> $stable(bus_addr)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !bus_write && !overflow); // R1
endmodule

bind smpl_wr_master smpl_wr_master_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_write (bus_write),
    .bus_wait  (bus_wait),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .overflow  (overflow),
    .base_load (base_load)
);

// File: tb/test_smpl_wr_master.sv
`timescale 1ns/1ps
module test_smpl_wr_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        base_load = 1'b0;
    logic [31:0] base_addr = '0;
    logic        bus_wait = 1'b0;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        overflow;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit force_wait = 1'b0;
    logic [7:0] stall_pat = 8'b0110_1110;
    int cyc = 0;
    logic [31:0] exp_addr = '0;
    logic [63:0] sb_q[$];
    int pushed = 0;
    int written = 0;

    always #10 clk = ~clk;

    smpl_wr_master i_smpl_wr_master (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .base_load(base_load), .base_addr(base_addr), .bus_wait(bus_wait),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave model: waitrequest changes just after each rising edge
    always @(posedge clk) begin
        #1;
        bus_wait = force_wait | stall_pat[cyc % 8];
        cyc++;
    end

    // monitor
    logic        p_wr = 1'b0, p_wait = 1'b0;
    logic [31:0] p_addr = '0, p_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_wr && p_wait) begin
                check(bus_write && bus_addr == p_addr && bus_wdata == p_data, "R4 hold",
                      {bus_addr, bus_wdata}, {p_addr, p_data});
            end
            if (p_wr && !p_wait) begin
                check(!bus_write, "R5 release", 64'(bus_write), 64'd0);
            end
            if (bus_write && !bus_wait) begin
                written++;
                check(bus_addr[1:0] == 2'b00, "R6 align", 64'(bus_addr), 64'(bus_addr & 32'hFFFF_FFFC));
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected write", {bus_addr, bus_wdata}, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = sb_q.pop_front();
                    check(bus_addr == e[63:32], "R6 address", 64'(bus_addr), 64'(e[63:32]));
                    check(bus_wdata == e[31:0], "R3 data", 64'(bus_wdata), 64'(e[31:0]));
                end
            end
        end
        p_wr = bus_write; p_wait = bus_wait; p_addr = bus_addr; p_data = bus_wdata;
    end

    task automatic send(input logic [31:0] d, input bit accept, input int hold);
        @(negedge clk);
        smp_data = d;
        @(negedge clk);
        smp_valid = 1'b1;
        if (accept) begin
            sb_q.push_back({exp_addr, d});
            exp_addr += 32'd4;
            pushed++;
        end
        repeat (hold) @(negedge clk);
        smp_valid = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    task automatic load_base(input logic [31:0] a, input bit take);
        @(negedge clk);
        base_addr = a;
        base_load = 1'b1;
        @(negedge clk);
        base_load = 1'b0;
        if (take) exp_addr = {a[31:2], 2'b00};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_write && !overflow && bus_addr == 0, "R1 in reset",
              {31'd0, bus_write, bus_addr}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!bus_write && !overflow && bus_addr == 0, "R1 after reset",
              {31'd0, bus_write, bus_addr}, 64'd0);

        // writes from reset address 0
        send(32'hA5A5_0001, 1'b1, 4);
        send(32'h0000_FFFF, 1'b1, 4);
        // R7 load with unaligned base: low bits dropped
        load_base(32'h0000_1003, 1'b1);
        check(bus_addr == 32'h0000_1000, "R7 load", 64'(bus_addr), 64'h1000);
        for (int i = 0; i < 6; i++) send(32'h1234_0000 + 32'(i * 7), 1'b1, 3 + i);
        // R2 long strobe still one write
        send(32'hDEAD_BEEF, 1'b1, 40);
        check(written == pushed, "R2 one write per strobe", 64'(written), 64'(pushed));

        // R7 load ignored while pending
        force_wait = 1'b1;
        send(32'h5555_AAAA, 1'b1, 4);
        check(bus_write == 1'b1, "R4 stalled write", 64'(bus_write), 64'd1);
        load_base(32'hDEAD_0000, 1'b0);
        check(bus_addr == exp_addr - 32'd4, "R7 ignored while pending", 64'(bus_addr), 64'(exp_addr - 32'd4));
        check(!overflow, "R8 no overflow yet", 64'(overflow), 64'd0);

        // R8 overflow: second sample while stalled is dropped
        send(32'hBAD0_BAD0, 1'b0, 4);
        check(overflow == 1'b1, "R8 overflow set", 64'(overflow), 64'd1);
        check(bus_wdata == 32'h5555_AAAA, "R8 pending data kept", 64'(bus_wdata), 64'h5555_AAAA);
        force_wait = 1'b0;
        repeat (10) @(negedge clk);
        send(32'h0BAD_F00D, 1'b1, 4);
        check(overflow == 1'b1, "R8 overflow sticky", 64'(overflow), 64'd1);

        stall_pat = 8'h00;
        send(32'h7777_0000, 1'b1, 2);
        send(32'h7777_0001, 1'b1, 2);
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R2 all written", 64'(sb_q.size()), 64'd0);
        check(written == pushed, "R8 dropped sample not written", 64'(written), 64'(pushed));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule